// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block deserialises stereo 24-bit PCM arriving on a three-wire serial audio link: a bit clock, a word clock that marks the left and right halves of each frame, and a data line. All three lines are sampled by a faster system clock. The bit clock's rising edges are found by edge detection, and every decision is taken on those edges.

A two-bit mode input selects the framing. In left-justified framing the first data bit follows the word-clock change directly. In I2S framing the data starts one bit clock later. In right-justified framing the word ends on the last bit clock before the next word-clock change. A half frame may hold more bit clocks than the word needs, and those extra cycles carry no data. When a right half completes, the left and right samples appear together on parallel outputs, with a valid strobe one system cycle wide.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, and on the cycle after, `pair_valid` is 0 and both sample outputs are zero.
- R2: With mode 2'b00 (left justified), the MSB is taken on the first rising bit-clock edge at which the new word-clock level is seen. The other 23 bits follow MSB first.
- R3: With mode 2'b01 (I2S), the MSB is taken on the second rising bit-clock edge after the word-clock change. The other 23 bits follow MSB first.
- R4: With mode 2'b10 (right justified), the LSB is the bit sampled on the last rising bit-clock edge before the word-clock change. The 23 bits before it make up the rest of the word, MSB first.
- R5: Extra bit clocks in a half frame are ignored, whatever their data. They come after the LSB in modes 00 and 01 and before the MSB in mode 10.
- R6: Word clock low carries the left sample and word clock high carries the right sample. After each right half completes, `left_out` and `right_out` present one frame's pair and `pair_valid` is high for exactly one system cycle. The sample outputs change only in that cycle.
- R7: In modes 00 and 01, a half frame shorter than 24 bit clocks gives a word whose missing low-order bits are zero.
- R8: The half frame that is already under way when reset is released is discarded. A pair is emitted only after a complete left half followed by a complete right half, so one pair is produced per full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Framing: 00 left justified, 01 I2S, 10 right justified |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word clock, low for the left channel and high for the right |
| sd | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Left sample of the last complete frame |
| right_out | output | 24 | Right sample of the last complete frame |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Each framing is driven with half frames of exactly 24, 25 and 32 bit clocks. Padding bits are driven high, so a receiver that counts from the wrong edge or fails to ignore padding returns shifted or corrupted words. Half frames of 16 and 20 bit clocks in the two start-aligned framings show whether the truncated words are zero-filled. The sample set includes a lone MSB, a lone LSB, all ones and all zeros, which expose swapped bit order and swapped channels. Every run starts with a partial right half and then counts the pairs it receives, which confirms that the partial half is dropped.

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
  parameter int WIDTH = 24,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             sck,
  input  logic             ws,
  input  logic             sd,
  output logic [WIDTH-1:0] left_out,
  output logic [WIDTH-1:0] right_out,
  output logic             pair_valid
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [1:0] M_I2S = 2'b01;
  localparam logic [1:0] M_RJ  = 2'b10;

  logic [SYNC:0]    sck_sy;
  logic [SYNC-1:0]  ws_sy, sd_sy;
  logic             ws_d1, ws_d2;
  logic [1:0]       primed;
  logic             armed, left_ok;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] acc, sr, left_hold;

  wire rise   = sck_sy[SYNC-1] & ~sck_sy[SYNC];
  wire ws_s   = ws_sy[SYNC-1];
  wire sd_s   = sd_sy[SYNC-1];
  wire is_rj  = (mode == M_RJ);
  wire is_i2s = (mode == M_I2S);
  wire cur    = is_i2s ? ws_d1 : ws_s;
  wire last   = is_i2s ? ws_d2 : ws_d1;
  wire flip   = rise & primed[1] & (cur != last);
  wire [WIDTH-1:0] word = is_rj ? sr : acc;
  wire [CW-1:0] pos = CW'(WIDTH - 1) - cnt;

  always_ff @(posedge clk) begin
    sck_sy <= {sck_sy[SYNC-1:0], sck};
    ws_sy  <= {ws_sy[SYNC-2:0], ws};
    sd_sy  <= {sd_sy[SYNC-2:0], sd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_d1      <= 1'b0;
      ws_d2      <= 1'b0;
      primed     <= '0;
      armed      <= 1'b0;
      left_ok    <= 1'b0;
      cnt        <= CW'(WIDTH);
      acc        <= '0;
      sr         <= '0;
      left_hold  <= '0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (rise) begin
        ws_d1  <= ws_s;
        ws_d2  <= ws_d1;
        primed <= {primed[0], 1'b1};
        sr     <= {sr[WIDTH-2:0], sd_s};
        if (flip) begin
          acc             <= '0;
          acc[WIDTH-1]    <= sd_s;
          cnt             <= CW'(1);
        end else if (cnt < CW'(WIDTH)) begin
          acc[pos] <= sd_s;
          cnt      <= cnt + CW'(1);
        end
      end
      if (flip) begin
        if (!armed) begin
          armed <= 1'b1;
        end else if (!last) begin
          left_hold <= word;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_out   <= left_hold;
          right_out  <= word;
          pair_valid <= 1'b1;
          left_ok    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
`timescale 1ns/1ps
module serial_audio_rx_chk #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] left_out,
  input logic [WIDTH-1:0] right_out,
  input logic             pair_valid
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!pair_valid && left_out == '0 && right_out == '0));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r6_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_out) |-> pair_valid);

  a_r6_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_out) |-> pair_valid);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .left_out(left_out),
  .right_out(right_out), .pair_valid(pair_valid)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  localparam int W  = 24;
  localparam int NF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sck = 1'b0, ws = 1'b1, sd = 1'b0;
  logic [W-1:0] left_out, right_out;
  logic pair_valid;

  int n_chk = 0, n_fail = 0, got = 0;
  logic prev_v = 1'b0;
  string tag = "R2";
  logic [W-1:0] exp_l [0:NF-1];
  logic [W-1:0] exp_r [0:NF-1];
  logic ws_l [0:511];
  logic sd_l [0:511];

  always #5 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sck(sck), .ws(ws), .sd(sd),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  task automatic chk(input bit ok, input string t, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, expv);
    end
  endtask

  function automatic logic [W-1:0] gen(input int f, input int ch, input int run);
    if (f == 0) return ch ? 24'h000001 : 24'h800000;
    if (f == 1) return ch ? 24'h000000 : 24'hFFFFFF;
    return W'(((f * 32'h2A0F3) + (ch * 32'h91B7C) + (run * 32'h13579)) ^ 32'h5C3A96);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair_valid) begin
        if (got < NF) begin
          chk(left_out == exp_l[got], {tag, " R6 left"}, left_out, exp_l[got]);
          chk(right_out == exp_r[got], {tag, " R6 right"}, right_out, exp_r[got]);
        end else begin
          chk(1'b0, "R8 extra pair", W'(got), W'(NF));
        end
        got++;
      end
      if (prev_v) chk(!pair_valid, "R6 strobe width", W'(pair_valid), '0);
    end
    prev_v = pair_valid;
  end

  task automatic run(input logic [1:0] m, input int slot, input int id, input string t);
    int n;
    int pad;
    logic [W-1:0] d;
    logic [W-1:0] keep;
    rst_n = 1'b0;
    mode  = m;
    tag   = t;
    repeat (5) @(posedge clk);
    #2;
    chk(!pair_valid && left_out == '0 && right_out == '0, "R1 reset state", left_out | right_out, '0);
    got = 0;
    keep = (slot >= W || m == 2'b10) ? '1 : ~((W'(1) << (W - slot)) - W'(1));
    pad  = (slot > W) ? slot - W : 0;
    n = 0;
    for (int i = 0; i < 5; i++) begin ws_l[n] = 1'b1; sd_l[n] = 1'b1; n++; end
    for (int f = 0; f < NF; f++) begin
      exp_l[f] = gen(f, 0, id) & keep;
      exp_r[f] = gen(f, 1, id) & keep;
      for (int ch = 0; ch < 2; ch++) begin
        d = gen(f, ch, id);
        for (int k = 0; k < slot; k++) begin
          ws_l[n] = ch[0];
          if (m == 2'b10) sd_l[n] = (k < pad) ? 1'b1 : d[W-1-(k-pad)];
          else            sd_l[n] = (k < W) ? d[W-1-k] : 1'b1;
          n++;
        end
      end
    end
    for (int i = 0; i < 4; i++) begin ws_l[n] = 1'b0; sd_l[n] = 1'b0; n++; end
    rst_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      ws  = (m == 2'b01 && i + 1 < n) ? ws_l[i+1] : ws_l[i];
      sd  = sd_l[i];
      #40;
      sck = 1'b1;
      #40;
    end
    sck = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    chk(got == NF, {t, " R8 pair count"}, W'(got), W'(NF));
  endtask

  initial begin
    #3;
    run(2'b00, 24, 1, "R2");
    run(2'b00, 25, 2, "R2 R5");
    run(2'b00, 32, 3, "R2 R5");
    run(2'b01, 24, 4, "R3");
    run(2'b01, 25, 5, "R3 R5");
    run(2'b01, 32, 6, "R3 R5");
    run(2'b10, 24, 7, "R4");
    run(2'b10, 25, 8, "R4 R5");
    run(2'b10, 32, 9, "R4 R5");
    run(2'b00, 16, 10, "R7 LJ");
    run(2'b00, 20, 11, "R7 LJ");
    run(2'b01, 16, 12, "R7 I2S");
    run(2'b01, 20, 13, "R7 I2S");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule